// File: doc/BRIEF.md
# Register Shadowing Bus Wrapper

This block sits between a system-bus slave port and the internal register bus of a core. It holds a local shadow copy of every core register. A system-bus read is answered from that copy one cycle after the request, and it never waits for the internal bus. A system-bus write updates the matching shadow at once. The write is also passed on to the core as a one-cycle internal-bus write.

A separate refresh scheduler keeps the shadows current. It raises a request with a register index. When the internal bus is free, the wrapper performs a two-cycle fetch: an address cycle, then a data cycle in which the core returns the value. The fetched value then overwrites the shadow. The wrapper arbitrates the single internal bus between forwarded writes and these fetches. To a bus master, the register map and data behave as though the core were accessed directly.

Top module: `rsw_wrapper`

## Requirements
- R1: After synchronous reset, every shadow holds RESET_VAL (default 0), `sb_ready` is 1, and `sb_rvalid`, `ib_rd`, `ib_wr` and `pf_ack` are 0.
- R2: A read (`sb_valid`=1, `sb_write`=0) sampled at a clock edge gives `sb_rvalid`=1 in the following cycle, whatever the internal bus is doing, and it causes no internal-bus activity.
- R3: A write is accepted at an edge where `sb_valid`=1, `sb_write`=1 and `sb_ready`=1. It updates that register's shadow at that edge, so a read in the next cycle returns the written data.
- R4: Every accepted write appears on the internal bus exactly once, as one cycle with `ib_wr`=1 carrying the write's index on `ib_addr` and its data on `ib_wdata`. Writes reach the core in acceptance order.
- R5: A fetch drives `ib_rd`=1 with the index on `ib_addr` for one cycle. It then holds the bus for a second cycle with `ib_rd`=0 and `ib_wr`=0. `ib_rdata` is sampled at the end of that second cycle and written into the shadow.
- R6: When an accepted write (or a pending one) and `pf_req` compete for a free internal bus, the write is issued first. The request stays pending.
- R7: A write accepted during the address cycle of a fetch is held until the fetch's second cycle ends. While it is held, `sb_ready`=0 and further writes are refused.
- R8: If a write to a register is accepted while a fetch of that same register is in progress, the fetched value is discarded. The shadow keeps the written data.
- R9: `pf_ack` pulses for exactly the cycle in which a requested fetch drives `ib_rd`, and only for a request that was present at the preceding edge.
- R10: `ib_rd` and `ib_wr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sb_valid | input | 1 | System-bus request valid |
| sb_write | input | 1 | 1 = write, 0 = read |
| sb_addr | input | ADDR_W | Register index |
| sb_wdata | input | DATA_W | Write data |
| sb_ready | output | 1 | Write slot free; writes are accepted only when 1 |
| sb_rvalid | output | 1 | Read data valid, one cycle after the read |
| sb_rdata | output | DATA_W | Read data from the shadow |
| pf_req | input | 1 | Refresh scheduler asks to fetch a register |
| pf_addr | input | ADDR_W | Index to fetch |
| pf_ack | output | 1 | Request taken; fetch address cycle active |
| ib_rd | output | 1 | Internal-bus fetch address cycle |
| ib_wr | output | 1 | Internal-bus write strobe |
| ib_addr | output | ADDR_W | Internal-bus register index |
| ib_wdata | output | DATA_W | Internal-bus write data |
| ib_rdata | input | DATA_W | Core read data, valid in the cycle after `ib_rd` |

## Verification
Several rules are checked by assertions on every cycle:
- mutual exclusion of the internal-bus strobes;
- the fixed one-cycle read latency;
- read-after-write data;
- write priority over a fetch on a free bus;
- the two-cycle fetch occupancy;
- the blocking of `sb_ready` behind a fetch;
- the link between `pf_ack` and a prior request.

Other behaviour depends on the core's contents over longer histories: discarding a stale fetch, a refreshed shadow exposing a value the core changed internally, and write ordering into the core. Only the bench's scenarios and its cycle-by-cycle reference model can show these.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE       = 2'd0,
    PH_FETCH_ADDR = 2'd1,
    PH_FETCH_DATA = 2'd2,
    PH_WRITE      = 2'd3
  } ib_phase_e;

endpackage

// File: rtl/rsw_shadow_bank.sv
module rsw_shadow_bank #(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = '0,
  localparam int NUM_REGS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bw_en,
  input  logic [ADDR_W-1:0] bw_addr,
  input  logic [DATA_W-1:0] bw_data,
  input  logic              rf_en,
  input  logic [ADDR_W-1:0] rf_addr,
  input  logic [DATA_W-1:0] rf_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] shadow [NUM_REGS];

  // One flop word per register: bus write wins over a refresh of the same word.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[g] <= RESET_VAL;
      end else if (bw_en && bw_addr == ADDR_W'(g)) begin
        shadow[g] <= bw_data;
      end else if (rf_en && rf_addr == ADDR_W'(g)) begin
        shadow[g] <= rf_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= shadow[rd_addr];
      end
    end
  end

endmodule

// File: rtl/rsw_wr_slot.sv
module rsw_wr_slot #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);

  logic              held;
  logic [ADDR_W-1:0] held_addr;
  logic [DATA_W-1:0] held_data;

  assign out_ready = ~held;
  assign out_valid = held | in_valid;
  assign out_addr  = held ? held_addr : in_addr;
  assign out_data  = held ? held_data : in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
    end else if (held) begin
      if (take) begin
        held <= 1'b0;
      end
    end else if (in_valid && !take) begin
      held <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!held && in_valid && !take) begin
      held_addr <= in_addr;
      held_data <= in_data;
    end
  end

endmodule

// File: rtl/rsw_ib_sequencer.sv
module rsw_ib_sequencer
  import rsw_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_take,
  input  logic              pf_req,
  input  logic [ADDR_W-1:0] pf_addr,
  output logic              pf_ack,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              ib_rd,
  output logic              ib_wr,
  output logic [ADDR_W-1:0] ib_addr,
  output logic [DATA_W-1:0] ib_wdata,
  input  logic [DATA_W-1:0] ib_rdata,
  output logic              rf_en,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_data
);

  ib_phase_e phase, phase_nxt;
  logic      bus_free;
  logic      start_fetch;
  logic      stale;

  // The bus is held only across the address cycle of a fetch.
  assign bus_free    = (phase != PH_FETCH_ADDR);
  assign wr_take     = bus_free & wr_valid;
  assign start_fetch = bus_free & ~wr_valid & pf_req;

  always_comb begin
    phase_nxt = PH_IDLE;
    if (!bus_free) begin
      phase_nxt = PH_FETCH_DATA;
    end else if (wr_valid) begin
      phase_nxt = PH_WRITE;
    end else if (pf_req) begin
      phase_nxt = PH_FETCH_ADDR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      ib_rd    <= 1'b0;
      ib_wr    <= 1'b0;
      pf_ack   <= 1'b0;
      stale    <= 1'b0;
      ib_addr  <= '0;
      ib_wdata <= '0;
    end else begin
      phase  <= phase_nxt;
      ib_rd  <= (phase_nxt == PH_FETCH_ADDR);
      ib_wr  <= (phase_nxt == PH_WRITE);
      pf_ack <= start_fetch;
      if (wr_take) begin
        ib_addr  <= wr_addr;
        ib_wdata <= wr_data;
      end else if (start_fetch) begin
        ib_addr <= pf_addr;
      end
      if (phase == PH_FETCH_ADDR) begin
        stale <= snoop_valid && (snoop_addr == ib_addr);
      end
    end
  end

  // Same-edge collisions in the data cycle are resolved by the bank's priority.
  assign rf_en   = (phase == PH_FETCH_DATA) && !stale;
  assign rf_addr = ib_addr;
  assign rf_data = ib_rdata;

endmodule

// File: rtl/rsw_wrapper.sv
module rsw_wrapper #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sb_valid,
  input  logic              sb_write,
  input  logic [ADDR_W-1:0] sb_addr,
  input  logic [DATA_W-1:0] sb_wdata,
  output logic              sb_ready,
  output logic              sb_rvalid,
  output logic [DATA_W-1:0] sb_rdata,
  input  logic              pf_req,
  input  logic [ADDR_W-1:0] pf_addr,
  output logic              pf_ack,
  output logic              ib_rd,
  output logic              ib_wr,
  output logic [ADDR_W-1:0] ib_addr,
  output logic [DATA_W-1:0] ib_wdata,
  input  logic [DATA_W-1:0] ib_rdata
);

  logic              acc_wr, acc_rd;
  logic              slot_ready, slot_valid, slot_take;
  logic [ADDR_W-1:0] slot_addr;
  logic [DATA_W-1:0] slot_data;
  logic              rf_en;
  logic [ADDR_W-1:0] rf_addr;
  logic [DATA_W-1:0] rf_data;

  assign acc_wr   = sb_valid & sb_write & slot_ready;
  assign acc_rd   = sb_valid & ~sb_write;
  assign sb_ready = slot_ready;

  rsw_wr_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_slot (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (acc_wr),
    .in_addr   (sb_addr),
    .in_data   (sb_wdata),
    .take      (slot_take),
    .out_ready (slot_ready),
    .out_valid (slot_valid),
    .out_addr  (slot_addr),
    .out_data  (slot_data)
  );

  rsw_ib_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk         (clk),
    .rst         (rst),
    .wr_valid    (slot_valid),
    .wr_addr     (slot_addr),
    .wr_data     (slot_data),
    .wr_take     (slot_take),
    .pf_req      (pf_req),
    .pf_addr     (pf_addr),
    .pf_ack      (pf_ack),
    .snoop_valid (acc_wr),
    .snoop_addr  (sb_addr),
    .ib_rd       (ib_rd),
    .ib_wr       (ib_wr),
    .ib_addr     (ib_addr),
    .ib_wdata    (ib_wdata),
    .ib_rdata    (ib_rdata),
    .rf_en       (rf_en),
    .rf_addr     (rf_addr),
    .rf_data     (rf_data)
  );

  rsw_shadow_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) i_bank (
    .clk      (clk),
    .rst      (rst),
    .bw_en    (acc_wr),
    .bw_addr  (sb_addr),
    .bw_data  (sb_wdata),
    .rf_en    (rf_en),
    .rf_addr  (rf_addr),
    .rf_data  (rf_data),
    .rd_en    (acc_rd),
    .rd_addr  (sb_addr),
    .rd_valid (sb_rvalid),
    .rd_data  (sb_rdata)
  );

endmodule

// File: rtl/rsw_wrapper_chk.sv
module rsw_wrapper_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sb_valid,
  input logic              sb_write,
  input logic [ADDR_W-1:0] sb_addr,
  input logic [DATA_W-1:0] sb_wdata,
  input logic              sb_ready,
  input logic              sb_rvalid,
  input logic [DATA_W-1:0] sb_rdata,
  input logic              pf_req,
  input logic              pf_ack,
  input logic              ib_rd,
  input logic              ib_wr
);

  assert_bus_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(ib_rd && ib_wr));

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (sb_valid && !sb_write) |=> sb_rvalid);

  assert_read_after_write_R3: assert property (@(posedge clk) disable iff (rst)
    (sb_valid && sb_write && sb_ready) ##1 (sb_valid && !sb_write && sb_addr == $past(sb_addr))
      |=> (sb_rdata == $past(sb_wdata, 2)));

  assert_write_priority_R6: assert property (@(posedge clk) disable iff (rst)
    (sb_valid && sb_write && sb_ready && !ib_rd) |=> (ib_wr && !pf_ack));

  assert_fetch_two_cycles_R5: assert property (@(posedge clk) disable iff (rst)
    ib_rd |=> (!ib_rd && !ib_wr));

  assert_write_held_R7: assert property (@(posedge clk) disable iff (rst)
    (sb_valid && sb_write && sb_ready && ib_rd) |=> !sb_ready);

  assert_ack_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pf_ack) |-> $past(pf_req));

endmodule

bind rsw_wrapper rsw_wrapper_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .sb_valid  (sb_valid),
  .sb_write  (sb_write),
  .sb_addr   (sb_addr),
  .sb_wdata  (sb_wdata),
  .sb_ready  (sb_ready),
  .sb_rvalid (sb_rvalid),
  .sb_rdata  (sb_rdata),
  .pf_req    (pf_req),
  .pf_ack    (pf_ack),
  .ib_rd     (ib_rd),
  .ib_wr     (ib_wr)
);

// File: tb/test_rsw_wrapper.sv
module test_rsw_wrapper;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int NR = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          sb_valid = 1'b0, sb_write = 1'b0;
  logic [AW-1:0] sb_addr = '0;
  logic [DW-1:0] sb_wdata = '0;
  logic          sb_ready, sb_rvalid;
  logic [DW-1:0] sb_rdata;
  logic          pf_req = 1'b0;
  logic [AW-1:0] pf_addr = '0;
  logic          pf_ack, ib_rd, ib_wr;
  logic [AW-1:0] ib_addr;
  logic [DW-1:0] ib_wdata;
  logic [DW-1:0] ib_rdata;

  rsw_wrapper #(.ADDR_W(AW), .DATA_W(DW)) i_rsw_wrapper (
    .clk(clk), .rst(rst), .sb_valid(sb_valid), .sb_write(sb_write),
    .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_ready(sb_ready),
    .sb_rvalid(sb_rvalid), .sb_rdata(sb_rdata), .pf_req(pf_req),
    .pf_addr(pf_addr), .pf_ack(pf_ack), .ib_rd(ib_rd), .ib_wr(ib_wr),
    .ib_addr(ib_addr), .ib_wdata(ib_wdata), .ib_rdata(ib_rdata)
  );

  // Core model: registered read data, writes land at the strobe edge, internal pokes.
  logic [DW-1:0] core_mem [NR];
  logic          poke_en = 1'b0;
  logic [AW-1:0] poke_addr = '0;
  logic [DW-1:0] poke_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) core_mem[i] <= '0;
      ib_rdata <= '0;
    end else begin
      if (ib_rd) ib_rdata <= core_mem[ib_addr];
      if (ib_wr) core_mem[ib_addr] <= ib_wdata;
      else if (poke_en) core_mem[poke_addr] <= poke_data;
    end
  end

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  int            m_ph;      // 0 idle, 1 fetch address, 2 fetch data, 3 write
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;
  bit            m_stale;
  logic [DW-1:0] m_sh [NR];
  logic [AW+DW-1:0] m_pend [$];
  bit            m_rvalid;
  logic [DW-1:0] m_rdata;
  bit            m_live = 1'b0;

  always @(posedge clk) begin
    bit acc_wr, acc_rd;
    if (rst) begin
      m_ph = 0; m_stale = 0; m_rvalid = 0; m_rdata = '0; m_addr = '0; m_wdata = '0;
      for (int i = 0; i < NR; i++) m_sh[i] = '0;
      m_pend.delete();
      m_live = 1'b1;
    end else begin
      acc_rd = sb_valid && !sb_write;
      acc_wr = sb_valid && sb_write && (m_pend.size() == 0);
      m_rvalid = acc_rd;
      if (acc_rd) m_rdata = m_sh[sb_addr];
      if (m_ph == 2 && !m_stale) m_sh[m_addr] = ib_rdata;
      if (acc_wr) m_sh[sb_addr] = sb_wdata;
      if (m_ph == 1) begin
        m_stale = acc_wr && (sb_addr == m_addr);
        m_ph = 2;
        if (acc_wr) m_pend.push_back({sb_addr, sb_wdata});
      end else if (m_pend.size() > 0) begin
        {m_addr, m_wdata} = m_pend.pop_front();
        m_ph = 3;
      end else if (acc_wr) begin
        m_addr = sb_addr; m_wdata = sb_wdata; m_ph = 3;
      end else if (pf_req) begin
        m_addr = pf_addr; m_ph = 1;
      end else begin
        m_ph = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (m_live && !rst) begin
      check(sb_ready == (m_pend.size() == 0), "R7", "sb_ready", DW'(sb_ready), DW'(m_pend.size() == 0));
      check(sb_rvalid == m_rvalid, "R2", "sb_rvalid", DW'(sb_rvalid), DW'(m_rvalid));
      if (m_rvalid) check(sb_rdata == m_rdata, "R3", "sb_rdata", sb_rdata, m_rdata);
      check(ib_rd == (m_ph == 1), "R5", "ib_rd", DW'(ib_rd), DW'(m_ph == 1));
      check(ib_wr == (m_ph == 3), "R4", "ib_wr", DW'(ib_wr), DW'(m_ph == 3));
      check(pf_ack == (m_ph == 1), "R9", "pf_ack", DW'(pf_ack), DW'(m_ph == 1));
      if (m_ph == 1 || m_ph == 3) check(ib_addr == m_addr, "R6", "ib_addr", DW'(ib_addr), DW'(m_addr));
      if (m_ph == 3) check(ib_wdata == m_wdata, "R4", "ib_wdata", ib_wdata, m_wdata);
      check(!(ib_rd && ib_wr), "R10", "strobe overlap", DW'(ib_rd && ib_wr), '0);
    end
  end

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    sb_valid = 1'b1; sb_write = 1'b0; sb_addr = a;
    @(negedge clk);
    sb_valid = 1'b0;
    d = sb_rdata;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!sb_ready) @(negedge clk);
    sb_valid = 1'b1; sb_write = 1'b1; sb_addr = a; sb_wdata = d;
    @(negedge clk);
    sb_valid = 1'b0; sb_write = 1'b0;
  endtask

  task automatic do_fetch(input logic [AW-1:0] a);
    pf_req = 1'b1; pf_addr = a;
    @(negedge clk);
    while (!pf_ack) @(negedge clk);
    pf_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state and cleared shadows
    check(sb_ready && !sb_rvalid && !ib_rd && !ib_wr && !pf_ack, "R1", "outputs after reset",
          DW'({sb_ready, sb_rvalid, ib_rd, ib_wr, pf_ack}), DW'(5'b10000));
    for (int i = 0; i < NR; i++) begin
      do_read(AW'(i), d);
      check(d == '0, "R1", "shadow reset value", d, '0);
    end

    // R3/R4: write then read back each register; core receives the data
    for (int i = 0; i < NR; i++) begin
      do_write(AW'(i), 32'hA500_0000 + 32'(i));
      do_read(AW'(i), d);
      check(d == 32'hA500_0000 + 32'(i), "R3", "read after write", d, 32'hA500_0000 + 32'(i));
    end
    @(negedge clk);
    check(core_mem[7] == 32'hA500_0007, "R4", "core got write", core_mem[7], 32'hA500_0007);

    // R5: core changes internally; shadow shows it only after a fetch
    poke_en = 1'b1; poke_addr = 3'd5; poke_data = 32'hCAFE_0005;
    @(negedge clk);
    poke_en = 1'b0;
    do_read(3'd5, d);
    check(d == 32'hA500_0005, "R5", "shadow before fetch", d, 32'hA500_0005);
    do_fetch(3'd5);
    do_read(3'd5, d);
    check(d == 32'hCAFE_0005, "R5", "shadow after fetch", d, 32'hCAFE_0005);

    // R6: write and request in the same cycle
    sb_valid = 1'b1; sb_write = 1'b1; sb_addr = 3'd2; sb_wdata = 32'h0000_2222;
    pf_req = 1'b1; pf_addr = 3'd6;
    @(negedge clk);
    sb_valid = 1'b0; sb_write = 1'b0;
    check(ib_wr && !ib_rd && ib_addr == 3'd2, "R6", "write first", DW'({ib_wr, ib_rd, ib_addr}), DW'({1'b1, 1'b0, 3'd2}));
    @(negedge clk);
    check(ib_rd && pf_ack && ib_addr == 3'd6, "R6", "fetch next", DW'({ib_rd, pf_ack, ib_addr}), DW'({1'b1, 1'b1, 3'd6}));
    pf_req = 1'b0;
    @(negedge clk);

    // R2/R7/R8: write to the register being fetched during its address cycle
    @(negedge clk);
    poke_en = 1'b1; poke_addr = 3'd3; poke_data = 32'hBAD0_0003;
    @(negedge clk);
    poke_en = 1'b0;
    pf_req = 1'b1; pf_addr = 3'd3;
    @(negedge clk);
    pf_req = 1'b0;
    check(ib_rd, "R5", "fetch started", DW'(ib_rd), 1);
    sb_valid = 1'b1; sb_write = 1'b1; sb_addr = 3'd3; sb_wdata = 32'h600D_0003;
    @(negedge clk);
    sb_write = 1'b0; sb_addr = 3'd3;
    check(!sb_ready && !ib_wr, "R7", "write held behind fetch", DW'({sb_ready, ib_wr}), 0);
    @(negedge clk);
    sb_valid = 1'b0;
    check(sb_rvalid && sb_rdata == 32'h600D_0003, "R2", "read during fetch data cycle", sb_rdata, 32'h600D_0003);
    check(ib_wr && ib_addr == 3'd3, "R7", "held write issued", DW'({ib_wr, ib_addr}), DW'({1'b1, 3'd3}));
    @(negedge clk);
    do_read(3'd3, d);
    check(d == 32'h600D_0003, "R8", "stale fetch discarded", d, 32'h600D_0003);
    check(core_mem[3] == 32'h600D_0003, "R4", "core holds held write", core_mem[3], 32'h600D_0003);

    // Mixed random traffic, compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      sb_valid = 1'($urandom_range(0, 1));
      sb_write = 1'($urandom_range(0, 1));
      sb_addr  = AW'($urandom_range(0, NR - 1));
      sb_wdata = $urandom;
      poke_en  = ($urandom_range(0, 7) == 0);
      poke_addr = AW'($urandom_range(0, NR - 1));
      poke_data = $urandom;
      if (pf_ack) pf_req = 1'b0;
      else if (!pf_req && $urandom_range(0, 2) == 0) begin
        pf_req = 1'b1; pf_addr = AW'($urandom_range(0, NR - 1));
      end
      @(negedge clk);
    end
    sb_valid = 1'b0; poke_en = 1'b0; pf_req = 1'b0;
    repeat (4) @(negedge clk);

    // R5: after refreshing all registers, every shadow matches the core
    for (int i = 0; i < NR; i++) do_fetch(AW'(i));
    for (int i = 0; i < NR; i++) begin
      do_read(AW'(i), d);
      check(d == core_mem[i], "R5", "refreshed shadow matches core", d, core_mem[i]);
    end
    summary();
  end

endmodule